// File: doc/BRIEF.md
# Lane-Isolated Increment/Decrement Unit

This ALU slice adds or subtracts one in a single sub-field of a 32-bit operand. The field may be one byte lane, one 16-bit half, or the whole word. The arithmetic stays inside the chosen field. If the field wraps, no carry or borrow reaches the neighbouring bits, and every bit outside the field is passed through as it was. The wrap is reported only through a carry flag. A zero flag reports whether the updated field is zero.

Each cycle the operand, the direction, the size, the lane index and two flag-write enables are sampled at the rising clock edge. The result word appears one cycle later. The Z and C flags are registers, and each one changes only when its own write enable was high at that edge. The unit is meant to sit in a datapath whose decode, register writeback and conditional execution are handled elsewhere.

Top module: `lane_incdec`

## Requirements
- R1: With `size` = 2'b00 the field is byte lane `idx` (0 to 3), bits [8*idx+7 : 8*idx]. That lane of `result` is the operand lane plus or minus one, modulo 256.
- R2: With `size` = 2'b01 the field is half `idx[0]`: 0 means bits [15:0] and 1 means bits [31:16]. `idx[1]` has no effect.
- R3: With `size` = 2'b10 or 2'b11 the field is all 32 bits and `idx` has no effect.
- R4: Every bit of `result` outside the field equals the operand bit. A wrap of the field never changes a neighbouring bit.
- R5: `dec` = 1 subtracts one from the field, and `dec` = 0 adds one.
- R6: When `c_we` is high, `c_flag` becomes 1 if the field wrapped and 0 otherwise. A wrap is all-ones to zero on increment, or zero to all-ones on decrement.
- R7: When `z_we` is high, `z_flag` becomes 1 exactly when the updated field is zero, whatever the bits outside it hold.
- R8: A flag whose write enable is low keeps its previous value.
- R9: `result`, `z_flag` and `c_flag` are registered. A synchronous high `rst` clears all three. Inputs sampled at one edge appear after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| operand | input | 32 | Operand word |
| dec | input | 1 | 0 = increment, 1 = decrement |
| size | input | 2 | 00 byte, 01 half, 1x full word |
| idx | input | 2 | Lane or half index |
| z_we | input | 1 | Zero-flag write enable |
| c_we | input | 1 | Carry-flag write enable |
| result | output | 32 | Registered result word |
| z_flag | output | 1 | Registered zero flag |
| c_flag | output | 1 | Registered carry/borrow flag |

## Verification
The assertions assume that every input is a known value at each clock edge once reset has been released. They also assume that the size and index codes are always decoded into exactly one lowest lane inside the field. All four size codes and all four index codes are legal, so the random stimulus draws every input over its full range. The stimulus holds all inputs steady from one falling edge to the next. Directed cases force the values at the field edges (all-ones and zero) into every size, next to neighbour bytes that would show any carry that leaked across a boundary.

// File: rtl/lane_incdec_pkg.sv
package lane_incdec_pkg;
  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  // codes 2'b10 and 2'b11 both select the full word
endpackage

// File: rtl/incdec_field_sel.sv
module incdec_field_sel #(
  parameter int NUM_LANES = 4,
  parameter int IDX_W     = 2
) (
  input  logic [1:0]           size,
  input  logic [IDX_W-1:0]     idx,
  output logic [NUM_LANES-1:0] lane_in,
  output logic [NUM_LANES-1:0] lane_lo,
  output logic [NUM_LANES-1:0] lane_hi
);
  import lane_incdec_pkg::*;
  localparam int HALF_LANES = NUM_LANES / 2;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    localparam logic UPPER   = (i >= HALF_LANES);
    localparam logic HALF_LO = ((i % HALF_LANES) == 0);
    localparam logic HALF_HI = ((i % HALF_LANES) == HALF_LANES - 1);
    localparam logic WORD_LO = (i == 0);
    localparam logic WORD_HI = (i == NUM_LANES - 1);

    always_comb begin
      case (size)
        SZ_BYTE: begin
          lane_in[i] = (idx == IDX_W'(i));
          lane_lo[i] = 1'b1;
          lane_hi[i] = 1'b1;
        end
        SZ_HALF: begin
          lane_in[i] = (idx[0] == UPPER);
          lane_lo[i] = HALF_LO;
          lane_hi[i] = HALF_HI;
        end
        default: begin
          lane_in[i] = 1'b1;
          lane_lo[i] = WORD_LO;
          lane_hi[i] = WORD_HI;
        end
      endcase
    end
  end
endmodule

// File: rtl/incdec_lane_seg.sv
module incdec_lane_seg #(
  parameter int LANE_W = 8
) (
  input  logic [LANE_W-1:0] din,
  input  logic              in_field,
  input  logic              dec,
  input  logic              cin,
  output logic [LANE_W-1:0] dout,
  output logic              cout
);
  logic [LANE_W:0] sum;

  always_comb begin
    sum = {1'b0, din} + {1'b0, {LANE_W{dec}}} + {{LANE_W{1'b0}}, cin};
    if (in_field) begin
      dout = sum[LANE_W-1:0];
      cout = sum[LANE_W];
    end else begin
      dout = din;
      cout = 1'b0;
    end
  end
endmodule

// File: rtl/lane_incdec.sv
module lane_incdec #(
  parameter int WORD_W = 32,
  parameter int LANE_W = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [WORD_W-1:0]                 operand,
  input  logic                              dec,
  input  logic [1:0]                        size,
  input  logic [$clog2(WORD_W/LANE_W)-1:0]  idx,
  input  logic                              z_we,
  input  logic                              c_we,
  output logic [WORD_W-1:0]                 result,
  output logic                              z_flag,
  output logic                              c_flag
);
  localparam int NUM_LANES = WORD_W / LANE_W;
  localparam int IDX_W     = $clog2(NUM_LANES);

  logic [NUM_LANES-1:0] lane_in, lane_lo, lane_hi;
  logic [NUM_LANES-1:0] cin, cout, lane_zero;
  logic [WORD_W-1:0]    next_word, fmask;
  logic                 field_cout, field_wrap, field_zero;

  incdec_field_sel #(.NUM_LANES(NUM_LANES), .IDX_W(IDX_W)) u_sel (
    .size(size), .idx(idx),
    .lane_in(lane_in), .lane_lo(lane_lo), .lane_hi(lane_hi)
  );

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_seg
    if (i == 0) begin : g_first
      assign cin[i] = ~dec;
    end else begin : g_rest
      assign cin[i] = lane_lo[i] ? ~dec : cout[i-1];
    end

    incdec_lane_seg #(.LANE_W(LANE_W)) u_seg (
      .din(operand[i*LANE_W +: LANE_W]), .in_field(lane_in[i]), .dec(dec),
      .cin(cin[i]), .dout(next_word[i*LANE_W +: LANE_W]), .cout(cout[i])
    );

    assign lane_zero[i] = ~lane_in[i] || (next_word[i*LANE_W +: LANE_W] == '0);
    assign fmask[i*LANE_W +: LANE_W] = {LANE_W{lane_in[i]}};
  end

  assign field_cout = |(cout & lane_hi & lane_in);
  assign field_wrap = dec ? ~field_cout : field_cout;
  assign field_zero = &lane_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      z_flag <= 1'b0;
      c_flag <= 1'b0;
    end else begin
      result <= next_word;
      if (z_we) z_flag <= field_zero;
      if (c_we) c_flag <= field_wrap;
    end
  end

  // R1 R2 R3: the decoded field has exactly one lowest lane
  assert_one_low_lane_R1: assert property (@(posedge clk) disable iff (rst)
    $countones(lane_lo & lane_in) == 1);

  // R4: bits outside the field come through untouched
  assert_outside_kept_R4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((result ^ $past(operand)) & ~$past(fmask)) == '0));

  // R6: increment of an all-ones field sets carry
  assert_inc_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (c_we && !dec && ((operand & fmask) == fmask)) |=> c_flag);

  // R6: decrement of a zero field sets borrow
  assert_dec_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (c_we && dec && ((operand & fmask) == '0)) |=> c_flag);

  // R7: zero flag follows the registered field only
  assert_zero_field_R7: assert property (@(posedge clk) disable iff (rst)
    z_we |=> (z_flag == ((result & $past(fmask)) == '0)));

  // R8: disabled flags hold
  assert_z_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !z_we |=> $stable(z_flag));
  assert_c_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !c_we |=> $stable(c_flag));
endmodule

// File: tb/test_lane_incdec.sv
module test_lane_incdec;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] operand = '0;
  logic        dec = 1'b0;
  logic [1:0]  size = 2'b00;
  logic [1:0]  idx = 2'b00;
  logic        z_we = 1'b0;
  logic        c_we = 1'b0;
  logic [31:0] result;
  logic        z_flag, c_flag;

  int compared = 0;
  int mismatched = 0;
  logic mz = 1'b0, mc = 1'b0;
  bit done = 0;

  always #4 clk = ~clk;

  lane_incdec i_lane_incdec (
    .clk(clk), .rst(rst), .operand(operand), .dec(dec), .size(size), .idx(idx),
    .z_we(z_we), .c_we(c_we), .result(result), .z_flag(z_flag), .c_flag(c_flag)
  );

  function automatic logic [31:0] mask_of(logic [1:0] sz, logic [1:0] ix);
    if (sz == 2'b00) return 32'hFF << (8 * ix);
    if (sz == 2'b01) return 32'hFFFF << (16 * ix[0]);
    return 32'hFFFF_FFFF;
  endfunction

  function automatic int shift_of(logic [1:0] sz, logic [1:0] ix);
    if (sz == 2'b00) return 8 * ix;
    if (sz == 2'b01) return 16 * ix[0];
    return 0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_vec(logic [31:0] op, logic d, logic [1:0] sz, logic [1:0] ix,
                         logic zw, logic cw);
    logic [31:0] m, fm, fld, nf, exp;
    int sh;
    string base;
    m   = mask_of(sz, ix);
    sh  = shift_of(sz, ix);
    fm  = m >> sh;
    fld = (op >> sh) & fm;
    nf  = (d ? fld - 1 : fld + 1) & fm;
    exp = (op & ~m) | (nf << sh);
    if (zw) mz = (nf == 0);
    if (cw) mc = d ? (fld == 0) : (fld == fm);
    operand = op; dec = d; size = sz; idx = ix; z_we = zw; c_we = cw;
    @(negedge clk);
    base = (sz == 2'b00) ? "R1" : (sz == 2'b01) ? "R2" : "R3";
    if (d) base = {base, "/R5"};
    chk(base, result & m, exp & m);
    chk("R4 outside bits", result & ~m, op & ~m);
    chk(zw ? "R7 zero flag" : "R8 zero hold", {31'd0, z_flag}, {31'd0, mz});
    chk(cw ? "R6 carry flag" : "R8 carry hold", {31'd0, c_flag}, {31'd0, mc});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset result", result, 32'd0);
    chk("R9 reset flags", {30'd0, z_flag, c_flag}, 32'd0);
    rst = 1'b0;
    // directed corners
    run_vec(32'h1122_FF44, 1'b0, 2'b00, 2'd1, 1'b1, 1'b1); // R1 no neighbour move
    run_vec(32'h12FF_3456, 1'b0, 2'b00, 2'd2, 1'b1, 1'b1); // R1 lane 2 wrap, Z
    run_vec(32'h0000_0000, 1'b1, 2'b00, 2'd3, 1'b1, 1'b1); // R5 byte borrow
    run_vec(32'hABCD_0000, 1'b1, 2'b01, 2'd2, 1'b1, 1'b1); // R2 idx[1] ignored
    run_vec(32'hFFFF_1234, 1'b0, 2'b01, 2'd3, 1'b1, 1'b1); // R2 upper half wrap
    run_vec(32'hFFFF_FFFF, 1'b0, 2'b10, 2'd2, 1'b1, 1'b1); // R3 full wrap
    run_vec(32'h0000_0000, 1'b1, 2'b11, 2'd1, 1'b1, 1'b1); // R3 full borrow
    run_vec(32'h0000_0001, 1'b1, 2'b00, 2'd0, 1'b1, 1'b0); // R7 zero only
    run_vec(32'h0000_00FF, 1'b0, 2'b00, 2'd0, 1'b0, 1'b0); // R8 both hold
    run_vec(32'h5555_5555, 1'b0, 2'b00, 2'd0, 1'b0, 1'b1); // R8 z hold
    // constrained random
    void'($urandom(32'd2024));
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] op;
      op = $urandom();
      case ($urandom_range(0, 3))
        0: op[7:0] = 8'hFF;
        1: op[15:8] = 8'h00;
        2: op[31:16] = 16'hFFFF;
        default: ;
      endcase
      run_vec(op, 1'($urandom()), 2'($urandom()), 2'($urandom()),
              1'($urandom()), 1'($urandom()));
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule